// File: doc/BRIEF.md
# Card Configuration and Control Register

This block is the configuration register that a local subsystem processor writes to set up a plug-in serial card. It is one 8-bit register. It chooses which of four legacy serial port address sets the UART answers to, and it enables address-mode selection and serial-bypass mode. It arms a status-change notification that fires on attribute-memory writes, and it steps the card through its power-up personality. The card starts as a busy memory card, then becomes a ready memory card, then becomes an I/O card with the UART enabled.

A single output line, `rdy_irq`, has two meanings. While the card is still in memory mode it is a busy/ready indication. Once I/O is enabled it passes the UART interrupt request straight through. Bit 6 is a self-clearing command bit: writing 1 to it drops the pending subsystem interrupt flag, and it always reads back as 0. Every input and output is a plain control or status pin. Nothing streams through the block, so there is no valid/ready handshake.

Top module: `card_cfg_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `rd_data` is 8'h22: the port field is 2'b10 (port 2) and bits [5:4] are 2'b10. At the same time `port_sel`=2'b10, and `io_en`, `rdy_irq`, `stschg`, `sub_irq`, `addr_mode_en` and `bypass_en` are all 0.
- R2: A cycle with `wr_en`=1 and `wr_addr`=12'h110 loads `wr_data` into the register, and `rd_data` shows it after that clock edge. A write to any other address leaves `rd_data` unchanged.
- R3: `port_sel` follows bits [1:0]. The codes are 2'b00 for port 1, 2'b10 for port 2, 2'b01 for port 3 and 2'b11 for port 4.
- R4: When bit 2 is 1, a cycle with `attr_wr`=1 sets `stschg` from the next cycle on. When bit 2 is 0, `attr_wr` has no effect on `stschg`.
- R5: `stschg` stays at 1 until a cycle with `stschg_ack`=1 clears it. If a new `attr_wr` arrives in the same cycle as the acknowledge, `stschg` stays at 1.
- R6: With bits [5:4]=2'b10, `io_en`=0 and `rdy_irq`=0 (busy), whatever `uart_irq` is.
- R7: With bits [5:4]=2'b11, `io_en`=0 and `rdy_irq`=1 (ready), whatever `uart_irq` is.
- R8: With bit 5=0, `io_en`=1 and `rdy_irq` equals `uart_irq` in the same cycle, whatever bit 4 is.
- R9: `irq_event`=1 sets `sub_irq` from the next cycle on. A register write with bit 6=1 clears it from the next cycle on, and `irq_event` wins when both happen in the same cycle. Bit 6 of `rd_data` always reads 0.
- R10: `addr_mode_en` follows bit 3 and `bypass_en` follows bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Subsystem write strobe |
| wr_addr | input | 12 | Subsystem write address |
| wr_data | input | 8 | Subsystem write data |
| rd_data | output | 8 | Register contents (bit 6 reads 0) |
| attr_wr | input | 1 | Attribute-memory write event |
| stschg_ack | input | 1 | Host acknowledge of status change |
| stschg | output | 1 | Status-change request to the host |
| irq_event | input | 1 | Event that raises the subsystem interrupt |
| sub_irq | output | 1 | Pending subsystem interrupt flag |
| uart_irq | input | 1 | Interrupt request from the UART |
| rdy_irq | output | 1 | Busy/ready line or UART interrupt request |
| io_en | output | 1 | UART I/O access enabled |
| port_sel | output | 2 | Host serial port selection |
| addr_mode_en | output | 1 | Address-mode selection enabled |
| bypass_en | output | 1 | Serial-bypass mode enabled |

## Verification
All configuration outputs are combinational decodes of the stored byte. A wrongly stored or wrongly reset bit therefore shows up on `rd_data` and on its decoded pin in the first cycle after the write or reset edge. The bench samples those pins right then. A faulty `rdy_irq` multiplex shows up within the same cycle that `uart_irq` toggles. A faulty sticky flag, whether it has the wrong priority or fails to hold, shows up one cycle after the colliding set and clear. The bench therefore drives such collisions on purpose.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;
  localparam int CFG_W = 8;

  // Field layout, MSB first: bit7 .. bit0
  typedef struct packed {
    logic       bypass;
    logic       irq_clr;
    logic       io_off;
    logic       ready;
    logic       addr_mode;
    logic       chg_ie;
    logic [1:0] port;
  } cfg_t;

  typedef enum logic [1:0] {
    PORT_1 = 2'b00,
    PORT_3 = 2'b01,
    PORT_2 = 2'b10,
    PORT_4 = 2'b11
  } port_e;

  localparam cfg_t CFG_RESET = '{bypass: 1'b0, irq_clr: 1'b0, io_off: 1'b1,
                                 ready: 1'b0, addr_mode: 1'b0, chg_ie: 1'b0,
                                 port: PORT_2};
endpackage

// File: rtl/ccfg_regfile.sv
module ccfg_regfile
  import card_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  output cfg_t              cfg_q,
  output logic              clr_pulse
);
  logic hit;
  cfg_t nxt;

  assign hit = wr_en && (wr_addr == REG_ADDR);

  always_comb begin
    nxt         = cfg_t'(wr_data);
    nxt.irq_clr = 1'b0;               // command bit, never stored
  end

  assign clr_pulse = hit && wr_data[6];

  always_ff @(posedge clk) begin
    if (rst)      cfg_q <= CFG_RESET;
    else if (hit) cfg_q <= nxt;
  end
endmodule

// File: rtl/ccfg_sticky_flag.sv
module ccfg_sticky_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  logic nxt;

  generate
    if (SET_WINS) begin : g_set_wins
      assign nxt = set_i | (flag_q & ~clr_i);
    end else begin : g_clr_wins
      assign nxt = ~clr_i & (set_i | flag_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= nxt;
  end
endmodule

// File: rtl/ccfg_line_mux.sv
module ccfg_line_mux
  import card_cfg_pkg::*;
(
  input  cfg_t cfg,
  input  logic uart_irq,
  output logic io_en,
  output logic rdy_irq
);
  always_comb begin
    io_en = ~cfg.io_off;
    if (cfg.io_off) rdy_irq = cfg.ready;   // memory card: busy(0)/ready(1)
    else            rdy_irq = uart_irq;    // I/O card: interrupt request
  end
endmodule

// File: rtl/card_cfg_ctrl.sv
module card_cfg_ctrl
  import card_cfg_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              attr_wr,
  input  logic              stschg_ack,
  output logic              stschg,
  input  logic              irq_event,
  output logic              sub_irq,
  input  logic              uart_irq,
  output logic              rdy_irq,
  output logic              io_en,
  output logic [1:0]        port_sel,
  output logic              addr_mode_en,
  output logic              bypass_en
);
  cfg_t cfg_q;
  logic clr_pulse;

  ccfg_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_q(cfg_q), .clr_pulse(clr_pulse)
  );

  // Status change: armed by the enable bit, a new event beats the acknowledge
  ccfg_sticky_flag #(.SET_WINS(1'b1)) u_chg (
    .clk(clk), .rst(rst), .set_i(attr_wr && cfg_q.chg_ie),
    .clr_i(stschg_ack), .flag_q(stschg)
  );

  // Subsystem interrupt: a new event beats the clear command
  ccfg_sticky_flag #(.SET_WINS(1'b1)) u_irq (
    .clk(clk), .rst(rst), .set_i(irq_event),
    .clr_i(clr_pulse), .flag_q(sub_irq)
  );

  ccfg_line_mux u_mux (
    .cfg(cfg_q), .uart_irq(uart_irq), .io_en(io_en), .rdy_irq(rdy_irq)
  );

  assign rd_data      = cfg_q;
  assign port_sel     = cfg_q.port;
  assign addr_mode_en = cfg_q.addr_mode;
  assign bypass_en    = cfg_q.bypass;
endmodule

// File: rtl/card_cfg_ctrl_chk.sv
module card_cfg_ctrl_chk #(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h110
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              attr_wr,
  input logic              stschg_ack,
  input logic              stschg,
  input logic              irq_event,
  input logic              sub_irq,
  input logic              uart_irq,
  input logic              rdy_irq,
  input logic              io_en
);
  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == 8'h22 && !stschg && !sub_irq && !rdy_irq));

  // R2
  foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != REG_ADDR) |=> $stable(rd_data));

  // R4
  chg_set_chk: assert property (@(posedge clk) disable iff (rst)
    (attr_wr && rd_data[2]) |=> stschg);

  // R5
  chg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stschg && !stschg_ack) |=> stschg);

  // R8
  line_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[5] |-> (io_en && rdy_irq == uart_irq));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_ADDR && wr_data[6] && !irq_event) |=> !sub_irq);
endmodule

bind card_cfg_ctrl card_cfg_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_data(rd_data), .attr_wr(attr_wr), .stschg_ack(stschg_ack),
  .stschg(stschg), .irq_event(irq_event), .sub_irq(sub_irq),
  .uart_irq(uart_irq), .rdy_irq(rdy_irq), .io_en(io_en)
);

// File: tb/tb_card_cfg_ctrl.sv
module tb_card_cfg_ctrl;
  localparam logic [11:0] RA = 12'h110;
  localparam int NV = 8;
  // {write data, uart_irq level}
  localparam logic [8:0] VEC [NV] = '{
    {8'h30, 1'b1}, {8'h20, 1'b1}, {8'h01, 1'b1}, {8'h11, 1'b0},
    {8'hCB, 1'b1}, {8'h7E, 1'b0}, {8'h88, 1'b0}, {8'h26, 1'b1}
  };

  logic clk = 0, rst = 1, wr_en = 0, attr_wr = 0, stschg_ack = 0;
  logic irq_event = 0, uart_irq = 0;
  logic [11:0] wr_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic stschg, sub_irq, rdy_irq, io_en, addr_mode_en, bypass_en;
  logic [1:0] port_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  card_cfg_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .attr_wr(attr_wr), .stschg_ack(stschg_ack),
    .stschg(stschg), .irq_event(irq_event), .sub_irq(sub_irq),
    .uart_irq(uart_irq), .rdy_irq(rdy_irq), .io_en(io_en),
    .port_sel(port_sel), .addr_mode_en(addr_mode_en), .bypass_en(bypass_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h22);
    chk("R1 port_sel", port_sel, 2'b10);
    chk("R1 io_en", io_en, 0);
    chk("R1 rdy_irq", rdy_irq, 0);
    chk("R1 flags", {stschg, sub_irq, addr_mode_en, bypass_en}, 0);

    // Table walk: R3 R6 R7 R8 R10, bit 6 readback R9
    for (int i = 0; i < NV; i++) begin
      logic [7:0] d;
      d = VEC[i][8:1];
      uart_irq = VEC[i][0];
      wr(RA, d);
      chk("R2 rd_data", rd_data, d & 8'hBF);
      chk("R9 bit6 reads 0", rd_data[6], 0);
      chk("R3 port_sel", port_sel, d[1:0]);
      chk("R6/R7/R8 io_en", io_en, !d[5]);
      chk("R6/R7/R8 rdy_irq", rdy_irq, d[5] ? d[4] : VEC[i][0]);
      chk("R10 addr_mode_en", addr_mode_en, d[3]);
      chk("R10 bypass_en", bypass_en, d[7]);
    end

    // R2 foreign address ignored
    wr(RA, 8'h31);
    wr(12'h120, 8'hC4);
    chk("R2 foreign write", rd_data, 8'h31);
    wr(12'h111, 8'h00);
    chk("R2 foreign write 2", rd_data, 8'h31);

    // R8 live follow
    wr(RA, 8'h10);
    uart_irq = 1; #1 chk("R8 follow high", rdy_irq, 1);
    uart_irq = 0; #1 chk("R8 follow low", rdy_irq, 0);
    // R6 busy ignores uart_irq
    wr(RA, 8'h20); uart_irq = 1; #1 chk("R6 busy", rdy_irq, 0);
    // R7 ready ignores uart_irq
    wr(RA, 8'h30); uart_irq = 0; #1 chk("R7 ready", rdy_irq, 1);

    // R4 disarmed: attr_wr ignored
    @(negedge clk); attr_wr = 1; @(negedge clk); attr_wr = 0;
    chk("R4 disarmed", stschg, 0);
    // R4 armed
    wr(RA, 8'h34);
    @(negedge clk); attr_wr = 1; @(negedge clk); attr_wr = 0;
    chk("R4 armed set", stschg, 1);
    repeat (3) @(negedge clk);
    chk("R5 holds", stschg, 1);
    stschg_ack = 1; @(negedge clk); stschg_ack = 0;
    chk("R5 ack clears", stschg, 0);
    attr_wr = 1; @(negedge clk); attr_wr = 0;
    stschg_ack = 1; attr_wr = 1; @(negedge clk); stschg_ack = 0; attr_wr = 0;
    chk("R5 set beats ack", stschg, 1);
    stschg_ack = 1; @(negedge clk); stschg_ack = 0;
    chk("R5 ack clears again", stschg, 0);

    // R9 subsystem interrupt
    irq_event = 1; @(negedge clk); irq_event = 0;
    chk("R9 event sets", sub_irq, 1);
    repeat (2) @(negedge clk);
    chk("R9 holds", sub_irq, 1);
    wr(RA, 8'h74);
    chk("R9 clear", sub_irq, 0);
    chk("R9 bit6 reads 0", rd_data, 8'h34);
    @(negedge clk); irq_event = 1; wr_en = 1; wr_addr = RA; wr_data = 8'h74;
    @(negedge clk); irq_event = 0; wr_en = 0;
    chk("R9 event beats clear", sub_irq, 1);
    wr(12'h100, 8'h40);
    chk("R9 foreign clear ignored", sub_irq, 1);

    // R1 reset again from a non-default state
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R1 re-reset rd_data", rd_data, 8'h22);
    chk("R1 re-reset flags", {stschg, sub_irq, io_en, rdy_irq}, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule